// File: doc/BRIEF.md
# Reset Time-out Sequencer

This block decides when a small processor core may leave reset and start executing. It reacts to five kinds of reset or wake event: the power-on pulse, a brown-out detect, the active-low external reset pin, a watchdog time-out (which resets the core when it is running and wakes it when it is asleep), and an interrupt wake from sleep. Depending on the event, the selected oscillator mode and a power-up timer enable, it runs a chain of two delays. The first is a power-up timer that counts ticks of a slow free-running clock. The second is an oscillator start-up counter that counts cycles of the oscillator clock.

Alongside the sequencing it keeps four reset-cause status bits: time-out, power-down, power-on and brown-out. Software reads these bits after the core starts to learn why it was reset. Software can set the power-on and brown-out bits back to 1 through two pulse inputs, so that the next event of that kind can be recognised. Every event input except the power-on pulse passes through a two-stage synchronizer clocked by the oscillator clock. The power-on pulse acts as the block's synchronous active-high reset.

Top module: `rst_timeout_seq`

## Requirements
- R1: While `por_pulse` is high, `core_rst` is 1 and `core_run` is 0. The status bits read time-out=1, power-down=1, power-on=0, brown-out=0.
- R2: After power-on with `pwrt_enable`=1, the core is released only after `PWRT_TICKS` rising edges of `slow_tick`. In crystal modes the start-up count follows that timer. The release takes at most 8 extra oscillator cycles of synchronizer and state latency.
- R3: `osc_mode` 0, 1 and 2 are crystal modes. In these modes the start-up stage counts `OST_CYCLES` oscillator cycles before release. `osc_mode` 3 is the RC mode, and it skips that stage.
- R4: With `pwrt_enable`=0, power-on release waits only the start-up count in crystal modes. In RC mode it has no time-out, only the synchronizer latency (at most 8 cycles).
- R5: While `brownout_det` is high, the core is held in reset and the power-up timer keeps restarting. After it falls, the full power-up timer always runs, followed by the start-up count in crystal modes. The event clears brown-out, sets time-out=1 and power-down=1, and leaves power-on unchanged.
- R6: A `sleep_enter` pulse in run stops the core (`core_run`=0) without asserting `core_rst`. An interrupt wake then applies only the start-up count (crystal modes), with `core_rst` never asserted, and sets (time-out, power-down) to (1,0).
- R7: A watchdog time-out while running asserts `core_rst` for a short pulse, sets (time-out, power-down) to (0,1), and the core runs again within 6 cycles if the pin is high.
- R8: A watchdog time-out during sleep wakes the core through the start-up count without asserting `core_rst`, and sets (time-out, power-down) to (0,0).
- R9: Pulling `ext_rst_n` low while running asserts `core_rst` and leaves all status bits unchanged. Pulling it low during sleep asserts `core_rst` and sets (time-out, power-down) to (1,0).
- R10: Time-outs run regardless of the pin. If `ext_rst_n` is held low past their expiry, the core stays in reset, and it runs within 4 cycles of the pin going high.
- R11: `sw_set_por` and `sw_set_bor` set the power-on and brown-out bits to 1. The power-on bit changes on no event other than `por_pulse`.
- R12: `core_rst` and `core_run` are never both 1.
- R13: A brown-out that arrives during a running start-up count restarts the sequence from the power-up timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_pulse | input | 1 | Power-on pulse, synchronous active-high reset of the block |
| brownout_det | input | 1 | Brown-out detect, high while supply is low |
| ext_rst_n | input | 1 | External reset pin, active low |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| sleep_enter | input | 1 | Core requests sleep |
| irq_wake | input | 1 | Interrupt wake request |
| osc_mode | input | 2 | 0,1,2 crystal modes; 3 RC mode |
| pwrt_enable | input | 1 | 1 enables the power-up timer at power-on |
| slow_tick | input | 1 | Slow timer clock, counted on rising edges |
| sw_set_por | input | 1 | Software pulse setting the power-on bit |
| sw_set_bor | input | 1 | Software pulse setting the brown-out bit |
| core_rst | output | 1 | Core held in reset |
| core_run | output | 1 | Core clock enable (running) |
| flag_timeout | output | 1 | Time-out status bit |
| flag_powerdown | output | 1 | Power-down status bit |
| flag_poweron | output | 1 | Power-on status bit |
| flag_brownout | output | 1 | Brown-out status bit |

## Verification
The checker enforces several properties on every cycle: the core is never both reset and running; a pin held low or a brown-out held for three cycles keeps the core out of run; the power-on bit moves only on power-on or a software set; and the brown-out bit falls only shortly after a brown-out detect. The bench alone can show the length of each delay chain. It sweeps every oscillator mode against both timer settings for power-on, brown-out and wake, and checks the release cycle against windows computed from the tick period and counts. It also covers the event-specific status encodings and the restart of an interrupted sequence.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    localparam logic [1:0] MODE_LP = 2'd0;
    localparam logic [1:0] MODE_XT = 2'd1;
    localparam logic [1:0] MODE_HS = 2'd2;
    localparam logic [1:0] MODE_RC = 2'd3;

    localparam int EV_SYNC_W = 6;

    typedef enum logic [2:0] {
        ST_PWRT  = 3'd0,
        ST_OST   = 3'd1,
        ST_HOLD  = 3'd2,
        ST_RUN   = 3'd3,
        ST_SLEEP = 3'd4,
        ST_WAKE  = 3'd5
    } seq_state_e;

    typedef enum logic [2:0] {
        EV_NONE      = 3'd0,
        EV_BROWNOUT  = 3'd1,
        EV_WDT_RST   = 3'd2,
        EV_WDT_WAKE  = 3'd3,
        EV_IRQ_WAKE  = 3'd4,
        EV_EXT_SLEEP = 3'd5,
        EV_EXT_RUN   = 3'd6
    } rst_event_e;

    typedef struct packed {
        logic timeout;
        logic powerdown;
        logic poweron;
        logic brownout;
    } status_t;

    // synchronized event bundle, MSB first
    typedef struct packed {
        logic brownout;
        logic ext_low;
        logic wdt;
        logic sleep;
        logic irq;
        logic tick;
    } sync_ev_t;

    // reset value of the synchronizer: pin treated as low until sampled high
    localparam logic [EV_SYNC_W-1:0] EV_SYNC_RST = 6'b010000;

    function automatic logic mode_needs_ost(logic [1:0] mode);
        return mode != MODE_RC;
    endfunction

    function automatic seq_state_e stage_after_pwrt(logic [1:0] mode);
        return mode_needs_ost(mode) ? ST_OST : ST_HOLD;
    endfunction

    function automatic seq_state_e stage_at_poweron(logic pwrt_on, logic [1:0] mode);
        return pwrt_on ? ST_PWRT : stage_after_pwrt(mode);
    endfunction

    function automatic seq_state_e stage_on_wake(logic [1:0] mode);
        return mode_needs_ost(mode) ? ST_WAKE : ST_RUN;
    endfunction

    function automatic logic state_holds_reset(seq_state_e st);
        return (st == ST_PWRT) || (st == ST_OST) || (st == ST_HOLD);
    endfunction

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= RST_VAL;
                    else     stage_q[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= RST_VAL;
                    else     stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/rst_seq_delay.sv
module rst_seq_delay #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    assign expired = (cnt_q == CNT_W'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst || clr)             cnt_q <= '0;
        else if (step && !expired)  cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rst_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  osc_mode,
    input  logic        pwrt_on,
    input  logic        ev_brownout,
    input  logic        ev_ext_low,
    input  logic        ev_wdt,
    input  logic        ev_sleep,
    input  logic        ev_irq,
    input  logic        pwrt_done,
    input  logic        ost_done,
    output seq_state_e  state,
    output rst_event_e  event_code,
    output logic        pwrt_clr,
    output logic        ost_clr
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d    = state_q;
        event_code = EV_NONE;
        if (ev_brownout) begin
            state_d    = ST_PWRT;
            event_code = EV_BROWNOUT;
        end else begin
            unique case (state_q)
                ST_PWRT: if (pwrt_done) state_d = stage_after_pwrt(osc_mode);
                ST_OST:  if (ost_done)  state_d = ST_HOLD;
                ST_HOLD: if (!ev_ext_low) state_d = ST_RUN;
                ST_RUN: begin
                    if (ev_wdt) begin
                        state_d    = ST_HOLD;
                        event_code = EV_WDT_RST;
                    end else if (ev_ext_low) begin
                        state_d    = ST_HOLD;
                        event_code = EV_EXT_RUN;
                    end else if (ev_sleep) begin
                        state_d    = ST_SLEEP;
                    end
                end
                ST_SLEEP: begin
                    if (ev_ext_low) begin
                        state_d    = ST_HOLD;
                        event_code = EV_EXT_SLEEP;
                    end else if (ev_wdt) begin
                        state_d    = stage_on_wake(osc_mode);
                        event_code = EV_WDT_WAKE;
                    end else if (ev_irq) begin
                        state_d    = stage_on_wake(osc_mode);
                        event_code = EV_IRQ_WAKE;
                    end
                end
                ST_WAKE: begin
                    if (ev_ext_low) begin
                        state_d    = ST_HOLD;
                        event_code = EV_EXT_SLEEP;
                    end else if (ost_done) begin
                        state_d    = ST_RUN;
                    end
                end
                default: state_d = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= stage_at_poweron(pwrt_on, osc_mode);
        else     state_q <= state_d;
    end

    assign state    = state_q;
    assign pwrt_clr = (state_q != ST_PWRT) || ev_brownout;
    assign ost_clr  = !((state_q == ST_OST) || (state_q == ST_WAKE));
endmodule

// File: rtl/rst_seq_status.sv
module rst_seq_status
    import rst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rst_event_e event_code,
    input  logic       set_por,
    input  logic       set_bor,
    output status_t    status
);
    status_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (event_code)
            EV_BROWNOUT: begin
                st_d.timeout   = 1'b1;
                st_d.powerdown = 1'b1;
                st_d.brownout  = 1'b0;
            end
            EV_WDT_RST: begin
                st_d.timeout   = 1'b0;
                st_d.powerdown = 1'b1;
            end
            EV_WDT_WAKE: begin
                st_d.timeout   = 1'b0;
                st_d.powerdown = 1'b0;
            end
            EV_IRQ_WAKE, EV_EXT_SLEEP: begin
                st_d.timeout   = 1'b1;
                st_d.powerdown = 1'b0;
            end
            default: ;
        endcase
        if (set_por) st_d.poweron = 1'b1;
        if (set_bor && (event_code != EV_BROWNOUT)) st_d.brownout = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{timeout: 1'b1, powerdown: 1'b1, poweron: 1'b0, brownout: 1'b0};
        else     st_q <= st_d;
    end

    assign status = st_q;
endmodule

// File: rtl/rst_timeout_seq.sv
module rst_timeout_seq
    import rst_seq_pkg::*;
#(
    parameter int PWRT_TICKS  = 72,
    parameter int OST_CYCLES  = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_pulse,
    input  logic       brownout_det,
    input  logic       ext_rst_n,
    input  logic       wdt_timeout,
    input  logic       sleep_enter,
    input  logic       irq_wake,
    input  logic [1:0] osc_mode,
    input  logic       pwrt_enable,
    input  logic       slow_tick,
    input  logic       sw_set_por,
    input  logic       sw_set_bor,
    output logic       core_rst,
    output logic       core_run,
    output logic       flag_timeout,
    output logic       flag_powerdown,
    output logic       flag_poweron,
    output logic       flag_brownout
);
    logic [EV_SYNC_W-1:0] raw_ev, sync_q;
    sync_ev_t   ev;
    logic       tick_prev_q, tick_rise;
    logic       pwrt_clr, ost_clr, pwrt_done, ost_done;
    seq_state_e state;
    rst_event_e event_code;
    status_t    status;

    assign raw_ev = {brownout_det, ~ext_rst_n, wdt_timeout, sleep_enter, irq_wake, slow_tick};

    rst_seq_sync #(.WIDTH(EV_SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(EV_SYNC_RST)) u_sync (
        .clk (clk),
        .rst (por_pulse),
        .d   (raw_ev),
        .q   (sync_q)
    );

    assign ev = sync_ev_t'(sync_q);

    always_ff @(posedge clk) begin
        if (por_pulse) tick_prev_q <= 1'b0;
        else           tick_prev_q <= ev.tick;
    end
    assign tick_rise = ev.tick & ~tick_prev_q;

    rst_seq_delay #(.LIMIT(PWRT_TICKS)) u_pwrt (
        .clk     (clk),
        .rst     (por_pulse),
        .clr     (pwrt_clr),
        .step    (tick_rise),
        .expired (pwrt_done)
    );

    rst_seq_delay #(.LIMIT(OST_CYCLES)) u_ost (
        .clk     (clk),
        .rst     (por_pulse),
        .clr     (ost_clr),
        .step    (1'b1),
        .expired (ost_done)
    );

    rst_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (por_pulse),
        .osc_mode    (osc_mode),
        .pwrt_on     (pwrt_enable),
        .ev_brownout (ev.brownout),
        .ev_ext_low  (ev.ext_low),
        .ev_wdt      (ev.wdt),
        .ev_sleep    (ev.sleep),
        .ev_irq      (ev.irq),
        .pwrt_done   (pwrt_done),
        .ost_done    (ost_done),
        .state       (state),
        .event_code  (event_code),
        .pwrt_clr    (pwrt_clr),
        .ost_clr     (ost_clr)
    );

    rst_seq_status u_status (
        .clk        (clk),
        .rst        (por_pulse),
        .event_code (event_code),
        .set_por    (sw_set_por),
        .set_bor    (sw_set_bor),
        .status     (status)
    );

    assign core_rst       = state_holds_reset(state);
    assign core_run       = (state == ST_RUN);
    assign flag_timeout   = status.timeout;
    assign flag_powerdown = status.powerdown;
    assign flag_poweron   = status.poweron;
    assign flag_brownout  = status.brownout;
endmodule

// File: rtl/rst_timeout_seq_chk.sv
module rst_timeout_seq_chk (
    input logic clk,
    input logic por_pulse,
    input logic brownout_det,
    input logic ext_rst_n,
    input logic sw_set_por,
    input logic core_rst,
    input logic core_run,
    input logic flag_poweron,
    input logic flag_brownout
);
    AST_RST_RUN_EXCLUSIVE: assert property (@(posedge clk) disable iff (por_pulse)
        !(core_rst && core_run)); // R12

    AST_PIN_LOW_BLOCKS_RUN: assert property (@(posedge clk) disable iff (por_pulse)
        (!$past(ext_rst_n, 1) && !$past(ext_rst_n, 2) && !$past(ext_rst_n, 3)) |-> !core_run); // R10

    AST_BROWNOUT_HOLDS_RESET: assert property (@(posedge clk) disable iff (por_pulse)
        ($past(brownout_det, 1) && $past(brownout_det, 2) && $past(brownout_det, 3)) |-> core_rst); // R5

    AST_POR_FLAG_STABLE: assert property (@(posedge clk) disable iff (por_pulse)
        (!$past(sw_set_por) && !$past(por_pulse)) |-> $stable(flag_poweron)); // R11

    AST_BOR_FALL_CAUSE: assert property (@(posedge clk) disable iff (por_pulse)
        $fell(flag_brownout) |-> ($past(brownout_det, 1) || $past(brownout_det, 2) || $past(brownout_det, 3))); // R5
endmodule

bind rst_timeout_seq rst_timeout_seq_chk chk_i (
    .clk           (clk),
    .por_pulse     (por_pulse),
    .brownout_det  (brownout_det),
    .ext_rst_n     (ext_rst_n),
    .sw_set_por    (sw_set_por),
    .core_rst      (core_rst),
    .core_run      (core_run),
    .flag_poweron  (flag_poweron),
    .flag_brownout (flag_brownout)
);

// File: tb/rst_timeout_seq_tb_top.sv
`timescale 1ns/1ps
module rst_timeout_seq_tb_top;
    localparam int T = 5;     // power-up timer ticks
    localparam int N = 32;    // start-up cycles
    localparam int P = 8;     // slow tick period in clocks
    localparam int SLACK = 8;

    logic clk = 1'b0;
    logic por_pulse = 1'b1, brownout_det = 1'b0, ext_rst_n = 1'b1;
    logic wdt_timeout = 1'b0, sleep_enter = 1'b0, irq_wake = 1'b0;
    logic [1:0] osc_mode = 2'd1;
    logic pwrt_enable = 1'b1, slow_tick = 1'b0;
    logic sw_set_por = 1'b0, sw_set_bor = 1'b0;
    logic core_rst, core_run;
    logic flag_timeout, flag_powerdown, flag_poweron, flag_brownout;
    logic [3:0] flags;
    int checks = 0, errors = 0, cyc = 0, tcnt = 0;

    always #2.5 clk = ~clk;

    rst_timeout_seq #(.PWRT_TICKS(T), .OST_CYCLES(N), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .por_pulse(por_pulse), .brownout_det(brownout_det), .ext_rst_n(ext_rst_n),
        .wdt_timeout(wdt_timeout), .sleep_enter(sleep_enter), .irq_wake(irq_wake),
        .osc_mode(osc_mode), .pwrt_enable(pwrt_enable), .slow_tick(slow_tick),
        .sw_set_por(sw_set_por), .sw_set_bor(sw_set_bor), .core_rst(core_rst), .core_run(core_run),
        .flag_timeout(flag_timeout), .flag_powerdown(flag_powerdown),
        .flag_poweron(flag_poweron), .flag_brownout(flag_brownout)
    );

    assign flags = {flag_timeout, flag_powerdown, flag_poweron, flag_brownout};

    always @(negedge clk) begin
        tcnt      <= (tcnt == P - 1) ? 0 : tcnt + 1;
        slow_tick <= (tcnt == P - 1);
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            summary();
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_range(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_run(input int lim, output int n, output bit saw_rst);
        n = 0; saw_rst = 0;
        while (!core_run && n < lim) begin
            @(negedge clk);
            n++;
            saw_rst |= core_rst;
        end
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    function automatic int lo_bound(input bit pw, input bit ost);
        return (pw ? (T - 1) * P : 0) + (ost ? N : 0);
    endfunction

    function automatic int hi_bound(input bit pw, input bit ost);
        return (pw ? T * P : 0) + (ost ? N : 0) + SLACK;
    endfunction

    initial begin
        int n;
        bit saw;
        // power-on sweep over every mode and timer setting
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 2; p++) begin
                osc_mode = 2'(m); pwrt_enable = p[0];
                @(negedge clk); por_pulse = 1'b1;
                cycles(3);
                check(core_rst && !core_run, "R1 reset holds core", {core_rst, core_run}, 2);
                check(flags == 4'b1100, "R1 status after power-on", flags, 4'b1100);
                por_pulse = 1'b0;
                wait_run(400, n, saw);
                if (p == 1) check_range("R2 power-up release window", n, lo_bound(1, m != 3), hi_bound(1, m != 3));
                else if (m == 3) check_range("R4 RC no time-out", n, 0, SLACK);
                else check_range("R4 R3 start-up only", n, lo_bound(0, 1), hi_bound(0, 1));
                check(flags == 4'b1100, "R1 status kept at run", flags, 4'b1100);
            end
        end
        // software sets
        pulse(sw_set_por); pulse(sw_set_bor);
        cycles(1);
        check(flags == 4'b1111, "R11 software sets", flags, 4'b1111);
        // brown-out per mode
        for (int m = 0; m < 4; m++) begin
            osc_mode = 2'(m);
            @(negedge clk); brownout_det = 1'b1;
            cycles(6);
            check(core_rst && !core_run, "R5 brown-out holds reset", {core_rst, core_run}, 2);
            check(flags == 4'b1110, "R5 brown-out status", flags, 4'b1110);
            brownout_det = 1'b0;
            wait_run(400, n, saw);
            check_range("R5 brown-out release window", n, lo_bound(1, m != 3), hi_bound(1, m != 3));
            pulse(sw_set_bor); cycles(1);
            check(flag_brownout == 1'b1, "R11 brown-out bit set", flag_brownout, 1);
        end
        // interrupt wake per mode
        for (int m = 0; m < 4; m++) begin
            osc_mode = 2'(m);
            pulse(sleep_enter); cycles(5);
            check(!core_run && !core_rst, "R6 sleep stops without reset", {core_rst, core_run}, 0);
            pulse(irq_wake);
            wait_run(200, n, saw);
            check_range("R6 wake window", n, (m != 3) ? N - 2 : 0, (m != 3) ? N + SLACK : SLACK);
            check(!saw, "R6 no reset on wake", saw, 0);
            check(flags == 4'b1011, "R6 wake status", flags, 4'b1011);
        end
        // watchdog reset in run
        osc_mode = 2'd1;
        pulse(wdt_timeout);
        saw = 0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); saw |= core_rst; end
        check(saw && core_run, "R7 watchdog reset pulse and resume", {saw, core_run}, 3);
        check(flags == 4'b0111, "R7 watchdog status", flags, 4'b0111);
        // watchdog wake from sleep
        pulse(sleep_enter); cycles(5);
        pulse(wdt_timeout);
        wait_run(200, n, saw);
        check_range("R8 watchdog wake window", n, N - 2, N + SLACK);
        check(!saw, "R8 no reset on watchdog wake", saw, 0);
        check(flags == 4'b0011, "R8 watchdog wake status", flags, 4'b0011);
        // pin low during run: nothing changes in status
        @(negedge clk); ext_rst_n = 1'b0;
        cycles(6);
        check(core_rst && !core_run, "R9 pin low resets core", {core_rst, core_run}, 2);
        check(flags == 4'b0011, "R9 pin in run leaves status", flags, 4'b0011);
        ext_rst_n = 1'b1;
        wait_run(20, n, saw);
        check_range("R9 pin release", n, 1, 4);
        // pin low during sleep
        pulse(sleep_enter); cycles(5);
        ext_rst_n = 1'b0; cycles(6);
        check(core_rst, "R9 pin in sleep resets", core_rst, 1);
        check(flags == 4'b1011, "R9 pin in sleep status", flags, 4'b1011);
        ext_rst_n = 1'b1;
        wait_run(20, n, saw);
        check(core_run, "R9 run after sleep pin", core_run, 1);
        // pin held low across the whole power-on sequence
        osc_mode = 2'd1; pwrt_enable = 1'b1;
        @(negedge clk); ext_rst_n = 1'b0; por_pulse = 1'b1;
        cycles(3); por_pulse = 1'b0;
        cycles(T * P + N + 40);
        check(core_rst && !core_run, "R10 held in reset by pin", {core_rst, core_run}, 2);
        check(flag_poweron == 1'b0, "R11 power-on bit cleared", flag_poweron, 0);
        ext_rst_n = 1'b1;
        wait_run(20, n, saw);
        check_range("R10 run after pin high", n, 1, 4);
        // brown-out during start-up count restarts the timer
        osc_mode = 2'd2;
        @(negedge clk); por_pulse = 1'b1;
        cycles(3); por_pulse = 1'b0;
        cycles(T * P + 12);
        check(core_rst, "R13 still in sequence", core_rst, 1);
        brownout_det = 1'b1; cycles(3); brownout_det = 1'b0;
        wait_run(400, n, saw);
        check_range("R13 restart from power-up timer", n, lo_bound(1, 1), hi_bound(1, 1));
        check(flag_poweron == 1'b0, "R11 power-on bit unchanged by brown-out", flag_poweron, 0);
        check(!(core_rst && core_run), "R12 exclusive outputs", {core_rst, core_run}, 1);
        summary();
    end
endmodule